// File: doc/BRIEF.md
# Dual-Clock Cascadable Up/Down Counter

This block is a binary counter whose direction is chosen by which of two count strobes rises: a rising edge on the up strobe adds one, and a rising edge on the down strobe subtracts one. The idle level of each strobe is HIGH. Both strobes are treated as asynchronous. They are brought into a single fast system clock domain through a short flop chain, and an edge is seen when the older sample is 0 and the newer one is 1. A parameter sets the counter width, and the count wraps modulo 2^WIDTH in both directions.

Clear and parallel preset are level-controlled but take effect at the next system clock edge. Clear wins over everything. An active-low load copies the data inputs into the count while it is held LOW, and any strobe edges seen during that time are dropped. Two active-low flags, carry and borrow, go LOW while the count sits at its top or bottom value and the matching strobe is LOW. Each flag therefore rises together with that strobe (after synchronisation). Feeding carry into the up strobe of a following stage, and borrow into its down strobe, chains stages into a wider counter with no extra logic. Preloading a start value gives a divide-by-N count length.

Top module: `updown_dual_counter`

## Requirements
- R1: While `rst` is HIGH at a clock edge, the next state is `count_o` = 0, `carry_n_o` = 1 and `borrow_n_o` = 1.
- R2: A 0-to-1 change on `cnt_up_i` while `cnt_dn_i` stays 1 adds one to `count_o`. The new value appears after the third rising `clk` edge following the change and is not visible after the second.
- R3: A 0-to-1 change on `cnt_dn_i` while `cnt_up_i` stays 1 subtracts one from `count_o`, with the same three-edge latency.
- R4: Counting wraps: up from all ones gives 0, and down from 0 gives all ones.
- R5: With `load_n_i` = 0 and `clr_i` = 0 at a clock edge, `count_o` takes `data_i` after that edge. Strobe edges that arrive while load is held are ignored and are not applied later.
- R6: With `clr_i` = 1 at a clock edge, `count_o` is 0 after that edge, whatever the values of `load_n_i`, `data_i` and both strobes.
- R7: `carry_n_o` is 0 only while `count_o` is all ones and the synchronised up strobe is 0. It follows a change on `cnt_up_i` after the second rising `clk` edge. Otherwise it is 1.
- R8: `borrow_n_o` is 0 only while `count_o` is 0 and the synchronised down strobe is 0, with the same two-edge latency. Otherwise it is 1.
- R9: If both strobes show a rising edge in the same cycle, `count_o` keeps its value.
- R10: Two stages chained (lower `carry_n_o` to upper `cnt_up_i`, lower `borrow_n_o` to upper `cnt_dn_i`) count as one counter of twice the width, across both the up and the down boundary.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| cnt_up_i | input | 1 | Up strobe, counts on its rising edge, idle HIGH |
| cnt_dn_i | input | 1 | Down strobe, counts on its rising edge, idle HIGH |
| load_n_i | input | 1 | Parallel preset, active low |
| clr_i | input | 1 | Clear to zero, active high, highest priority |
| data_i | input | WIDTH | Preset value |
| count_o | output | WIDTH | Current count |
| carry_n_o | output | 1 | Active-low overflow flag for chaining upward |
| borrow_n_o | output | 1 | Active-low underflow flag for chaining downward |

## Verification
The bench builds the block with its defaults, WIDTH = 4 and SYNC_STAGES = 2. This keeps both wrap boundaries only a handful of strobes away and lets the test count the three-edge strobe-to-count latency and the two-edge strobe-to-flag latency cycle by cycle. A second 4-bit instance chained to the first makes an 8-bit counter, so carry across the up boundary and borrow across the down boundary are both reached within a few dozen strobes.

// File: rtl/updc_pkg.sv
package updc_pkg;

    // What the count register does this cycle, in priority order
    typedef enum logic [1:0] {
        OP_COUNT = 2'd0,
        OP_LOAD  = 2'd1,
        OP_CLEAR = 2'd2
    } op_e;

    // Direction of a counting step
    typedef enum logic [1:0] {
        STEP_HOLD = 2'd0,
        STEP_INC  = 2'd1,
        STEP_DEC  = 2'd2
    } step_e;

    typedef struct packed {
        op_e   op;
        step_e step;
    } ctrl_t;

    // Two edges in one cycle cancel; a lone edge sets the direction
    function automatic step_e pick_step(input logic up_rise, input logic dn_rise);
        if (up_rise && !dn_rise)      return STEP_INC;
        else if (dn_rise && !up_rise) return STEP_DEC;
        else                          return STEP_HOLD;
    endfunction

    // Clear beats load, load beats counting
    function automatic op_e pick_op(input logic clr, input logic load_n);
        if (clr)          return OP_CLEAR;
        else if (!load_n) return OP_LOAD;
        else              return OP_COUNT;
    endfunction

endpackage

// File: rtl/updc_edge_sync.sv
module updc_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic async_i,
    output logic level_o,
    output logic rise_o
);
    // STAGES synchroniser flops plus one history flop for edge detection
    localparam int DEPTH = STAGES + 1;

    logic [DEPTH-1:0] chain;

    generate
        for (genvar i = 0; i < DEPTH; i++) begin : g_stage
            if (i == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (rst) chain[0] <= 1'b1;
                    else     chain[0] <= async_i;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (rst) chain[i] <= 1'b1;
                    else     chain[i] <= chain[i-1];
                end
            end
        end
    endgenerate

    assign level_o = chain[STAGES-1];
    assign rise_o  = chain[STAGES-1] & ~chain[STAGES];

endmodule

// File: rtl/updc_count_core.sv
module updc_count_core
    import updc_pkg::*;
#(
    parameter int WIDTH = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  ctrl_t            ctrl,
    input  logic [WIDTH-1:0] data,
    output logic [WIDTH-1:0] count
);
    localparam logic [WIDTH-1:0] ONE  = WIDTH'(1);
    localparam logic [WIDTH-1:0] ZERO = '0;

    logic [WIDTH-1:0] q;

    always_ff @(posedge clk) begin
        if (rst) begin
            q <= ZERO;
        end else begin
            unique case (ctrl.op)
                OP_CLEAR: q <= ZERO;
                OP_LOAD:  q <= data;
                default: begin
                    unique case (ctrl.step)
                        STEP_INC: q <= q + ONE;
                        STEP_DEC: q <= q - ONE;
                        default:  q <= q;
                    endcase
                end
            endcase
        end
    end

    assign count = q;

endmodule

// File: rtl/updc_flag_gen.sv
module updc_flag_gen #(
    parameter int WIDTH = 4
) (
    input  logic [WIDTH-1:0] count,
    input  logic             up_level,
    input  logic             dn_level,
    output logic             carry_n,
    output logic             borrow_n
);
    localparam logic [WIDTH-1:0] TOP    = '1;
    localparam logic [WIDTH-1:0] BOTTOM = '0;

    // Both terms come from flops, so the flags do not glitch on counting
    always_comb begin
        carry_n  = ~((count == TOP)    && !up_level);
        borrow_n = ~((count == BOTTOM) && !dn_level);
    end

endmodule

// File: rtl/updown_dual_counter.sv
module updown_dual_counter
    import updc_pkg::*;
#(
    parameter int WIDTH       = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cnt_up_i,
    input  logic             cnt_dn_i,
    input  logic             load_n_i,
    input  logic             clr_i,
    input  logic [WIDTH-1:0] data_i,
    output logic [WIDTH-1:0] count_o,
    output logic             carry_n_o,
    output logic             borrow_n_o
);
    logic  up_level, up_rise;
    logic  dn_level, dn_rise;
    ctrl_t ctrl;

    updc_edge_sync #(.STAGES(SYNC_STAGES)) u_up_sync (
        .clk    (clk),
        .rst    (rst),
        .async_i(cnt_up_i),
        .level_o(up_level),
        .rise_o (up_rise)
    );

    updc_edge_sync #(.STAGES(SYNC_STAGES)) u_dn_sync (
        .clk    (clk),
        .rst    (rst),
        .async_i(cnt_dn_i),
        .level_o(dn_level),
        .rise_o (dn_rise)
    );

    always_comb begin
        ctrl.op   = pick_op(clr_i, load_n_i);
        ctrl.step = pick_step(up_rise, dn_rise);
    end

    updc_count_core #(.WIDTH(WIDTH)) u_core (
        .clk  (clk),
        .rst  (rst),
        .ctrl (ctrl),
        .data (data_i),
        .count(count_o)
    );

    updc_flag_gen #(.WIDTH(WIDTH)) u_flags (
        .count   (count_o),
        .up_level(up_level),
        .dn_level(dn_level),
        .carry_n (carry_n_o),
        .borrow_n(borrow_n_o)
    );

endmodule

// File: rtl/updc_checker.sv
module updc_checker #(
    parameter int WIDTH = 4
) (
    input logic             clk,
    input logic             rst,
    input logic             load_n_i,
    input logic             clr_i,
    input logic [WIDTH-1:0] data_i,
    input logic [WIDTH-1:0] count_o,
    input logic             carry_n_o,
    input logic             borrow_n_o,
    input logic             up_rise,
    input logic             dn_rise
);
    localparam logic [WIDTH-1:0] ONE = WIDTH'(1);

    // R1
    reset_state_chk: assert property (@(posedge clk)
        rst |=> (count_o == '0 && carry_n_o && borrow_n_o));

    // R2
    inc_step_chk: assert property (@(posedge clk) disable iff (rst)
        (up_rise && !dn_rise && load_n_i && !clr_i) |=> count_o == $past(count_o) + ONE);

    // R3
    dec_step_chk: assert property (@(posedge clk) disable iff (rst)
        (dn_rise && !up_rise && load_n_i && !clr_i) |=> count_o == $past(count_o) - ONE);

    // R5
    preset_chk: assert property (@(posedge clk) disable iff (rst)
        (!load_n_i && !clr_i) |=> count_o == $past(data_i));

    // R6
    clear_chk: assert property (@(posedge clk) disable iff (rst)
        clr_i |=> count_o == '0);

    // R7
    carry_top_chk: assert property (@(posedge clk) disable iff (rst)
        !carry_n_o |-> count_o == '1);

    // R8
    borrow_bottom_chk: assert property (@(posedge clk) disable iff (rst)
        !borrow_n_o |-> count_o == '0);

    // R9
    idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
        ((up_rise == dn_rise) && load_n_i && !clr_i) |=> $stable(count_o));

endmodule

bind updown_dual_counter updc_checker #(.WIDTH(WIDTH)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .load_n_i  (load_n_i),
    .clr_i     (clr_i),
    .data_i    (data_i),
    .count_o   (count_o),
    .carry_n_o (carry_n_o),
    .borrow_n_o(borrow_n_o),
    .up_rise   (up_rise),
    .dn_rise   (dn_rise)
);

// File: tb/updown_dual_counter_bench.sv
module updown_dual_counter_bench;
    localparam int W = 4;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         up = 1'b1, dn = 1'b1, load_n = 1'b1, clr = 1'b0;
    logic [W-1:0] d_lo = '0, d_hi = '0;
    logic [W-1:0] q_lo, q_hi;
    logic         carry_lo, borrow_lo, carry_hi, borrow_hi;

    int n_checks = 0;
    int n_fail   = 0;

    always #5 clk = ~clk;

    updown_dual_counter #(.WIDTH(W)) u_updown_dual_counter (
        .clk(clk), .rst(rst), .cnt_up_i(up), .cnt_dn_i(dn),
        .load_n_i(load_n), .clr_i(clr), .data_i(d_lo),
        .count_o(q_lo), .carry_n_o(carry_lo), .borrow_n_o(borrow_lo)
    );

    // Upper stage of the chain for R10
    updown_dual_counter #(.WIDTH(W)) u_hi (
        .clk(clk), .rst(rst), .cnt_up_i(carry_lo), .cnt_dn_i(borrow_lo),
        .load_n_i(load_n), .clr_i(clr), .data_i(d_hi),
        .count_o(q_hi), .carry_n_o(carry_hi), .borrow_n_o(borrow_hi)
    );

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic preset(input logic [W-1:0] lo, input logic [W-1:0] hi);
        d_lo = lo; d_hi = hi; load_n = 1'b0;
        tick(1);
        load_n = 1'b1;
    endtask

    task automatic pulse_up();
        up = 1'b0; tick(3); up = 1'b1; tick(4);
    endtask

    task automatic pulse_dn();
        dn = 1'b0; tick(3); dn = 1'b1; tick(4);
    endtask

    task automatic t_reset();
        rst = 1'b1; tick(3); rst = 1'b0;
        check("R1 count", q_lo, 0);
        check("R1 carry", carry_lo, 1);
        check("R1 borrow", borrow_lo, 1);
    endtask

    task automatic t_up();
        preset(4'h6, 4'h0);
        up = 1'b0; tick(3); up = 1'b1;
        tick(2); check("R2 not yet after two edges", q_lo, 6);
        tick(1); check("R2 after three edges", q_lo, 7);
        tick(3);
        pulse_up(); pulse_up();
        check("R2 three steps", q_lo, 9);
    endtask

    task automatic t_down();
        preset(4'h9, 4'h0);
        dn = 1'b0; tick(3); dn = 1'b1;
        tick(2); check("R3 not yet after two edges", q_lo, 9);
        tick(1); check("R3 after three edges", q_lo, 8);
        tick(3);
        pulse_dn();
        check("R3 two steps", q_lo, 7);
    endtask

    task automatic t_wrap();
        preset(4'hF, 4'h0);
        check("R5 preset value", q_lo, 15);
        pulse_up();
        check("R4 up wrap", q_lo, 0);
        pulse_dn();
        check("R4 down wrap", q_lo, 15);
    endtask

    task automatic t_load_hold();
        d_lo = 4'hA; load_n = 1'b0;
        up = 1'b0; tick(3); up = 1'b1; tick(5);
        check("R5 strobe ignored under load", q_lo, 10);
        load_n = 1'b1; tick(5);
        check("R5 no late step", q_lo, 10);
    endtask

    task automatic t_clear();
        d_lo = 4'h5; load_n = 1'b0; clr = 1'b1;
        tick(1);
        check("R6 clear beats load", q_lo, 0);
        up = 1'b0; tick(3); up = 1'b1; tick(5);
        check("R6 clear beats strobe", q_lo, 0);
        clr = 1'b0; load_n = 1'b1; tick(5);
        check("R6 stays zero", q_lo, 0);
    endtask

    task automatic t_carry();
        preset(4'hF, 4'h0);
        check("R7 idle carry high", carry_lo, 1);
        dn = 1'b0; tick(2);
        check("R7 down strobe leaves carry", carry_lo, 1);
        dn = 1'b1; tick(5);
        preset(4'hF, 4'h0);
        up = 1'b0; tick(1);
        check("R7 carry after one edge", carry_lo, 1);
        tick(1);
        check("R7 carry low after two", carry_lo, 0);
        tick(2); up = 1'b1; tick(1);
        check("R7 carry still low", carry_lo, 0);
        tick(1);
        check("R7 carry released", carry_lo, 1);
        tick(1);
        check("R7 count wrapped", q_lo, 0);
        tick(4);
    endtask

    task automatic t_borrow();
        preset(4'h0, 4'h0);
        dn = 1'b0; tick(1);
        check("R8 borrow after one edge", borrow_lo, 1);
        tick(1);
        check("R8 borrow low after two", borrow_lo, 0);
        tick(2); dn = 1'b1; tick(2);
        check("R8 borrow released", borrow_lo, 1);
        tick(1);
        check("R8 count wrapped", q_lo, 15);
        tick(4);
    endtask

    task automatic t_both();
        preset(4'h5, 4'h0);
        up = 1'b0; dn = 1'b0; tick(3);
        up = 1'b1; dn = 1'b1; tick(5);
        check("R9 simultaneous edges hold", q_lo, 5);
    endtask

    task automatic t_chain();
        preset(4'h0, 4'h0);
        for (int i = 0; i < 16; i++) pulse_up();
        tick(4);
        check("R10 chain up carry", {q_hi, q_lo}, 8'h10);
        pulse_dn(); tick(4);
        check("R10 chain down borrow", {q_hi, q_lo}, 8'h0F);
        preset(4'hE, 4'h3);
        pulse_up(); pulse_up(); tick(4);
        check("R10 chain from preset", {q_hi, q_lo}, 8'h40);
    endtask

    initial begin
        tick(1);
        t_reset();
        t_up();
        t_down();
        t_wrap();
        t_load_hold();
        t_clear();
        t_carry();
        t_borrow();
        t_both();
        t_chain();
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

    initial begin
        #1000000;
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual hung expected done");
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

endmodule